// File: doc/BRIEF.md
# Soft Power Button Shutdown Sequencer

This block turns a soft power button into an orderly shutdown. It takes the level of the button interrupt, a panic flag, an acknowledge level from the operating system and a periodic timebase tick. It drives a green and a red status LED, a shutdown request to software, a power-off request and a hard-reset request. Every press masks further presses. The block then looks at the button level again after a fixed number of ticks. If the level is still high, it pulses a source-clear output and waits again. If the level is low, it accepts presses again.

A first accepted press raises the shutdown request and starts a grace timer, and the red LED begins to blink at a quarter-second rate. A second press, a press that software cannot accept, or the end of the grace timer asks for power-off at once. A panic turns the green LED off and switches the red LED to an eighth-second blink. After a panic, presses no longer start a shutdown. Instead, each completed debounce asks for a hard reset.

Top module: `pwrbtn_seq`

## Requirements
- R1: After reset, led_green is 1 and led_red, shutdown_request, power_off, hard_reset and src_clear are all 0.
- R2: A press is accepted only while the button gate is armed. A high btn_irq seen at a clock edge while the gate is armed disarms the gate. While disarmed, btn_irq has no effect on shutdown_request or power_off.
- R3: While disarmed, the gate examines btn_irq at the DEBOUNCE_TICKS-th tick (default 50) after disarming. If btn_irq is still 1, src_clear is 1 for one cycle and a new count of DEBOUNCE_TICKS ticks begins.
- R4: The gate re-arms only when btn_irq is 0 at the closing tick of a debounce count. A press before that tick is ignored.
- R5: A first accepted press with os_ack=1, no panic and no shutdown in progress sets shutdown_request. It also toggles led_red at that edge and then after every TICKS_PER_SEC/4 ticks.
- R6: An accepted press while a shutdown is in progress, or with os_ack=0, sets power_off at that edge. With os_ack=0 and no shutdown yet, shutdown_request stays 0.
- R7: power_off becomes 1 on the GRACE_SEC*TICKS_PER_SEC-th tick after the shutdown starts, and not before.
- R8: A panic (panic=1 at an edge) turns led_green off and toggles led_red at once and then after every TICKS_PER_SEC/8 ticks.
- R9: Only the first panic has an effect. Later panics change neither the LEDs nor the blink phase.
- R10: After a panic, an accepted press sets neither shutdown_request nor power_off. hard_reset becomes 1 on the closing tick of the debounce count that follows the press.
- R11: power_off and hard_reset stay 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase pulse, TICKS_PER_SEC per second |
| btn_irq | input | 1 | Button interrupt level |
| panic | input | 1 | Panic indication |
| os_ack | input | 1 | 1 when software accepts a shutdown request |
| led_green | output | 1 | Green LED on |
| led_red | output | 1 | Red LED on |
| shutdown_request | output | 1 | Shutdown asked of software |
| power_off | output | 1 | Power-off request, sticky |
| hard_reset | output | 1 | Hard-reset request, sticky |
| src_clear | output | 1 | One-cycle pulse clearing the button source |

## Verification
Every output is a register, so the result of an input change shows up after the first rising edge that samples it. Press, panic and tick inputs are driven on a falling edge and held for exactly one rising edge. The bench then reads the outputs at the next falling edge. Blink, grace and debounce results depend on a number of ticks rather than cycles. The bench counts each tick it applies, with random idle cycles in between, and computes the expected LED phase and timer expiry from that count. It checks just before and just after each closing tick.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;

    typedef enum logic {
        GATE_ARMED = 1'b0,
        GATE_WAIT  = 1'b1
    } gate_e;

    typedef enum logic [1:0] {
        BLINK_OFF  = 2'd0,
        BLINK_SLOW = 2'd1,
        BLINK_FAST = 2'd2
    } blink_e;

    typedef struct packed {
        logic start_shut;
        logic force_off;
    } press_act_t;

    // Decide what an accepted press does from the current block state.
    function automatic press_act_t decide_press(input logic shutting,
                                                input logic panicked,
                                                input logic os_ok);
        press_act_t a;
        a = '0;
        if (!panicked) begin
            if (shutting || !os_ok) a.force_off  = 1'b1;
            else                    a.start_shut = 1'b1;
        end
        return a;
    endfunction

    function automatic int unsigned quarter_ticks(input int unsigned tps);
        return (tps / 4 > 0) ? tps / 4 : 1;
    endfunction

    function automatic int unsigned eighth_ticks(input int unsigned tps);
        return (tps / 8 > 0) ? tps / 8 : 1;
    endfunction

endpackage

// File: rtl/pwrbtn_gate.sv
module pwrbtn_gate
    import pwrbtn_pkg::*;
#(
    parameter int unsigned DEBOUNCE_TICKS = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic btn_lvl,
    output logic press_o,
    output logic done_o,
    output logic src_clear_o
);
    localparam int unsigned CW = (DEBOUNCE_TICKS > 1) ? $clog2(DEBOUNCE_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_TICKS - 1);

    gate_e         state;
    logic [CW-1:0] cnt;
    logic          closing;

    assign press_o = (state == GATE_ARMED) && btn_lvl;
    assign closing = (state == GATE_WAIT) && tick && (cnt == LAST);
    assign done_o  = closing && !btn_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= GATE_ARMED;
            cnt         <= '0;
            src_clear_o <= 1'b0;
        end else begin
            src_clear_o <= 1'b0;
            case (state)
                GATE_ARMED: begin
                    if (btn_lvl) begin
                        state <= GATE_WAIT;
                        cnt   <= '0;
                    end
                end
                default: begin
                    if (closing) begin
                        cnt <= '0;
                        if (btn_lvl) src_clear_o <= 1'b1;
                        else         state       <= GATE_ARMED;
                    end else if (tick) begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    p_event_enters_wait_r2: assert property (@(posedge clk) disable iff (rst)
        press_o |=> (state == GATE_WAIT));

    p_clear_keeps_wait_r3: assert property (@(posedge clk) disable iff (rst)
        src_clear_o |-> (state == GATE_WAIT));

    p_rearm_needs_low_r4: assert property (@(posedge clk) disable iff (rst)
        ((state == GATE_WAIT) && !done_o) |=> (state == GATE_WAIT));

endmodule

// File: rtl/pwrbtn_blink.sv
module pwrbtn_blink
    import pwrbtn_pkg::*;
#(
    parameter int unsigned SLOW_TICKS = 16,
    parameter int unsigned FAST_TICKS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start_slow,
    input  logic start_fast,
    output logic red_o
);
    localparam int unsigned MAXP = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
    localparam int unsigned CW   = (MAXP > 1) ? $clog2(MAXP) : 1;
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_TICKS - 1);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_TICKS - 1);

    blink_e        mode;
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last = (mode == BLINK_FAST) ? FAST_LAST : SLOW_LAST;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode  <= BLINK_OFF;
            cnt   <= '0;
            red_o <= 1'b0;
        end else if (start_fast && mode != BLINK_FAST) begin
            mode  <= BLINK_FAST;
            cnt   <= '0;
            red_o <= ~red_o;
        end else if (start_slow && mode == BLINK_OFF) begin
            mode  <= BLINK_SLOW;
            cnt   <= '0;
            red_o <= ~red_o;
        end else if (mode != BLINK_OFF && tick) begin
            if (cnt == last) begin
                cnt   <= '0;
                red_o <= ~red_o;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_fast_is_final_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == BLINK_FAST) |=> (mode == BLINK_FAST));

    p_dark_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (mode == BLINK_OFF) |-> !red_o);

endmodule

// File: rtl/pwrbtn_grace.sv
module pwrbtn_grace #(
    parameter int unsigned LIMIT_TICKS = 7680
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic start,
    output logic expire_o
);
    localparam int unsigned GW = (LIMIT_TICKS > 1) ? $clog2(LIMIT_TICKS) : 1;
    localparam logic [GW-1:0] LAST = GW'(LIMIT_TICKS - 1);

    logic          running;
    logic [GW-1:0] cnt;

    assign expire_o = running && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            cnt     <= '0;
        end else if (start && !running) begin
            running <= 1'b1;
            cnt     <= '0;
        end else if (expire_o) begin
            running <= 1'b0;
        end else if (running && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_expire_once_r7: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !running);

endmodule

// File: rtl/pwrbtn_seq.sv
module pwrbtn_seq
    import pwrbtn_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC  = 64,
    parameter int unsigned GRACE_SEC      = 120,
    parameter int unsigned DEBOUNCE_TICKS = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic btn_irq,
    input  logic panic,
    input  logic os_ack,
    output logic led_green,
    output logic led_red,
    output logic shutdown_request,
    output logic power_off,
    output logic hard_reset,
    output logic src_clear
);
    localparam int unsigned SLOW  = quarter_ticks(TICKS_PER_SEC);
    localparam int unsigned FAST  = eighth_ticks(TICKS_PER_SEC);
    localparam int unsigned GRACE = GRACE_SEC * TICKS_PER_SEC;

    logic       press, deb_done, grace_expire;
    logic       shutting, panicked;
    logic       panic_new;
    press_act_t act;

    assign act       = decide_press(shutting, panicked, os_ack);
    assign panic_new = panic && !panicked;

    pwrbtn_gate #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_gate (
        .clk(clk), .rst(rst), .tick(tick), .btn_lvl(btn_irq),
        .press_o(press), .done_o(deb_done), .src_clear_o(src_clear)
    );

    pwrbtn_blink #(.SLOW_TICKS(SLOW), .FAST_TICKS(FAST)) u_blink (
        .clk(clk), .rst(rst), .tick(tick),
        .start_slow(press && act.start_shut),
        .start_fast(panic_new),
        .red_o(led_red)
    );

    pwrbtn_grace #(.LIMIT_TICKS(GRACE)) u_grace (
        .clk(clk), .rst(rst), .tick(tick),
        .start(press && act.start_shut),
        .expire_o(grace_expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            shutting         <= 1'b0;
            panicked         <= 1'b0;
            led_green        <= 1'b1;
            shutdown_request <= 1'b0;
            power_off        <= 1'b0;
            hard_reset       <= 1'b0;
        end else begin
            if (press && act.start_shut) begin
                shutting         <= 1'b1;
                shutdown_request <= 1'b1;
            end
            if ((press && act.force_off) || grace_expire) power_off <= 1'b1;
            if (panic_new) begin
                panicked  <= 1'b1;
                led_green <= 1'b0;
            end
            if (deb_done && panicked) hard_reset <= 1'b1;
        end
    end

    p_power_off_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        power_off |=> power_off);

    p_hard_reset_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        hard_reset |=> hard_reset);

    p_green_dark_after_panic_r8: assert property (@(posedge clk) disable iff (rst)
        panicked |-> !led_green);

    p_reset_needs_panic_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(hard_reset) |-> $past(panicked));

    p_grace_only_when_shutting_r7: assert property (@(posedge clk) disable iff (rst)
        grace_expire |-> shutting);

endmodule

// File: tb/sim_pwrbtn_seq.sv
module sim_pwrbtn_seq;
    localparam int TPS   = 64;
    localparam int GSEC  = 120;
    localparam int DEB   = 50;
    localparam int QTR   = TPS / 4;
    localparam int EIGHT = TPS / 8;
    localparam int GRACE = GSEC * TPS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, btn_irq = 1'b0, panic = 1'b0, os_ack = 1'b1;
    logic led_green, led_red, shutdown_request, power_off, hard_reset, src_clear;

    int n_chk = 0, n_fail = 0, cyc = 0, tk = 0;

    always #2 clk = ~clk;

    pwrbtn_seq #(.TICKS_PER_SEC(TPS), .GRACE_SEC(GSEC), .DEBOUNCE_TICKS(DEB)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .btn_irq(btn_irq), .panic(panic),
        .os_ack(os_ack), .led_green(led_green), .led_red(led_red),
        .shutdown_request(shutdown_request), .power_off(power_off),
        .hard_reset(hard_reset), .src_clear(src_clear)
    );

    function automatic logic exp_red(input int k, input int per);
        return logic'((1 + k / per) % 2);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; tick = 0; btn_irq = 0; panic = 0; os_ack = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        tk = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            repeat ($urandom % 3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            tk++;
        end
    endtask

    task automatic press_once();
        @(negedge clk);
        btn_irq = 1'b1;
        @(negedge clk);
        btn_irq = 1'b0;
    endtask

    task automatic panic_once();
        @(negedge clk);
        panic = 1'b1;
        @(negedge clk);
        panic = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // R1 reset state
        chk("R1 green", led_green, 1'b1);
        chk("R1 red", led_red, 1'b0);
        chk("R1 request", shutdown_request, 1'b0);
        chk("R1 power_off", power_off, 1'b0);
        chk("R1 hard_reset", hard_reset, 1'b0);
        chk("R1 src_clear", src_clear, 1'b0);

        // first press, held through the debounce count
        press_once();
        tk = 0;
        chk("R5 request", shutdown_request, 1'b1);
        chk("R5 red toggles at start", led_red, 1'b1);
        chk("R5 no power_off", power_off, 1'b0);
        @(negedge clk); btn_irq = 1'b1;
        ticks(DEB - 1);
        chk("R2 masked press", power_off, 1'b0);
        chk("R3 no clear early", src_clear, 1'b0);
        ticks(1);
        chk("R3 clear pulse", src_clear, 1'b1);
        chk("R5 red phase", led_red, exp_red(tk, QTR));
        btn_irq = 1'b0;
        ticks(DEB - 1);
        press_once();
        chk("R4 still masked", power_off, 1'b0);
        ticks(1);
        chk("R4 no clear when low", src_clear, 1'b0);
        for (int r = 0; r < 4; r++) begin
            ticks(1 + $urandom % 30);
            chk("R5 blink quarter", led_red, exp_red(tk, QTR));
        end
        press_once();
        chk("R6 second press", power_off, 1'b1);
        ticks(5);
        chk("R11 power_off sticky", power_off, 1'b1);

        // press software cannot accept
        do_reset();
        os_ack = 1'b0;
        press_once();
        chk("R6 os refuses power_off", power_off, 1'b1);
        chk("R6 os refuses request", shutdown_request, 1'b0);

        // grace expiry
        do_reset();
        press_once();
        tk = 0;
        ticks(GRACE - 1);
        chk("R7 before expiry", power_off, 1'b0);
        ticks(1);
        chk("R7 at expiry", power_off, 1'b1);
        repeat (20) @(negedge clk);
        chk("R11 sticky after expiry", power_off, 1'b1);

        // panic
        do_reset();
        panic_once();
        tk = 0;
        chk("R8 green off", led_green, 1'b0);
        chk("R8 red toggles", led_red, 1'b1);
        ticks(20);
        chk("R8 blink eighth", led_red, exp_red(tk, EIGHT));
        panic_once();
        chk("R9 second panic red", led_red, exp_red(tk, EIGHT));
        chk("R9 second panic green", led_green, 1'b0);
        ticks(3 + $urandom % 10);
        chk("R9 phase kept", led_red, exp_red(tk, EIGHT));
        press_once();
        chk("R10 no request", shutdown_request, 1'b0);
        chk("R10 no power_off", power_off, 1'b0);
        ticks(DEB - 1);
        chk("R10 reset not early", hard_reset, 1'b0);
        ticks(1);
        chk("R10 hard_reset", hard_reset, 1'b1);
        ticks(4);
        chk("R11 hard_reset sticky", hard_reset, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule